// File: doc/BRIEF.md
# Write-Only Two-Wire Bus Target Receiver

This block is the receive side of a two-wire serial bus target (I2C-compatible) in front of a multichannel converter. It samples the bus clock and data lines with a much faster system clock and decodes START, repeated START and STOP conditions from the synchronized samples. It then collects a 7-bit target address followed by a direction bit. The upper five address bits are fixed by a parameter, and two strap inputs supply the low two.

When the address matches and the transfer is a write, the block acknowledges the address and every data byte that follows. It pulls the data line low during each acknowledge clock and releases it at all other times. Each acknowledged data byte appears on a parallel output together with a one-cycle valid pulse. A separate one-cycle pulse marks the STOP that closes an addressed transaction. The block never drives the clock line, never stretches it and never returns data.

Top module: `twowire_wr_target`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits, MSB first, equal binary 10101 followed by strap_addr[1] and then strap_addr[0], and its eighth bit (direction) is 0.
- R2: An acknowledge holds sda_pull_low at 1 for the whole high phase of the ninth SCL clock. sda_pull_low is 0 while SCL is high during any of the eight bit clocks of a byte, and it changes only while SCL is low.
- R3: After an acknowledged address, every 8-bit data byte is shifted in MSB first and acknowledged. After its acknowledge clock ends, rx_byte carries the byte and rx_valid pulses high for exactly one cycle.
- R4: On an address mismatch, or when the direction bit is 1, no acknowledge is given. sda_pull_low stays 0 and rx_valid stays 0 until the next START or STOP.
- R5: After reset or a STOP, clock pulses and data bits are ignored until a START arrives. A complete byte sent in that state gets no acknowledge and produces no rx_valid.
- R6: A repeated START (SDA falling while SCL is high, with no STOP before it) returns the block to address reception without going idle. It produces no stop_seen pulse, and the transaction continues with the new address byte.
- R7: A STOP (SDA rising while SCL is high) releases SDA and returns the block to idle. stop_seen pulses for one cycle when the most recent address byte was acknowledged, and stays 0 otherwise.
- R8: A START or STOP that arrives in the middle of a byte discards the partial byte, and no rx_valid is produced for it.
- R9: While reset is active, sda_pull_low, rx_valid and stop_seen are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_addr | input | 2 | Low two address bits (bit 1 then bit 0 on the wire) |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_pull_low | output | 1 | 1 pulls SDA low, 0 releases it (open-drain control) |
| rx_byte | output | 8 | Last acknowledged data byte |
| rx_valid | output | 1 | One-cycle pulse when rx_byte is updated |
| stop_seen | output | 1 | One-cycle pulse on the STOP that ends an addressed transaction |

## Verification
The bench tries all four strap values and several near-miss addresses, including ones that differ only in a strap bit or only in the direction bit. A decoder that ignored the straps or the direction bit would acknowledge these and show up as a spurious acknowledge. It cuts bytes short with both STOP and repeated START. A design that kept the partial bits or stayed in a byte would then emit an extra rx_valid, or misalign the next address and miss its acknowledge. It also clocks whole bytes with no START in front of them, and it checks that stop_seen stays silent both across a repeated START and after a rejected address.

// File: rtl/twowire_pkg.sv
// Shared types for the two-wire write-only target receiver.
// Assumes byte-oriented transfers of RX_BYTE_W bits plus one acknowledge clock.
package twowire_pkg;
    localparam int RX_BYTE_W = 8;
    localparam int RX_CNT_W  = $clog2(RX_BYTE_W + 1);

    // Protocol phase of the receiver.
    typedef enum logic [2:0] {
        PH_IDLE,      // waiting for START
        PH_ADDR,      // shifting address + direction
        PH_ADDR_ACK,  // driving acknowledge for address
        PH_DATA,      // shifting a data byte
        PH_DATA_ACK,  // driving acknowledge for data
        PH_SKIP       // not addressed, waiting for START/STOP
    } rx_phase_t;
endpackage

// File: rtl/twowire_line_sampler.sv
// Synchronizes SCL and SDA into the system clock domain and decodes clock
// edges and bus conditions from the synchronized samples.
// Assumes the system clock is at least 16x the SCL rate, so every SCL phase
// spans several samples. Line index 0 is SCL and index 1 is SDA.
module twowire_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_now,
    output logic sda_now,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] line_raw;
    logic [N_LINES-1:0] line_now;
    logic [N_LINES-1:0] line_was;

    assign line_raw = {sda_raw, scl_raw};

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        logic [SYNC_STAGES-1:0] pipe;
        logic                   last;

        // Metastability pipeline plus one history flop; idle bus reads high.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pipe <= '1;
                last <= 1'b1;
            end else begin
                pipe <= {pipe[SYNC_STAGES-2:0], line_raw[g]};
                last <= pipe[SYNC_STAGES-1];
            end
        end

        assign line_now[g] = pipe[SYNC_STAGES-1];
        assign line_was[g] = last;
    end

    // Edge and condition decode on synchronized samples.
    always_comb begin
        scl_now   = line_now[0];
        sda_now   = line_now[1];
        scl_rise  =  line_now[0] & ~line_was[0];
        scl_fall  = ~line_now[0] &  line_was[0];
        start_det =  line_now[0] &  line_was[0] &  line_was[1] & ~line_now[1];
        stop_det  =  line_now[0] &  line_was[0] & ~line_was[1] &  line_now[1];
    end
endmodule

// File: rtl/twowire_rx_engine.sv
// Byte engine of the write-only target: shifts bits on SCL rising edges,
// matches the address, drives acknowledges and reports received bytes.
// Assumes clean edge and condition strobes from twowire_line_sampler; the
// acknowledge is raised and dropped on SCL falling edges only.
module twowire_rx_engine
    import twowire_pkg::*;
#(
    parameter int              HI_W    = 5,
    parameter logic [HI_W-1:0] ADDR_HI = 5'b10101,
    parameter int              STRAP_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [STRAP_W-1:0]   strap_addr,
    input  logic                 sda_now,
    input  logic                 scl_rise,
    input  logic                 scl_fall,
    input  logic                 start_det,
    input  logic                 stop_det,
    output logic                 pull_low,
    output logic [RX_BYTE_W-1:0] rx_byte,
    output logic                 rx_valid,
    output logic                 stop_seen
);
    localparam int ADDR_W = HI_W + STRAP_W;
    localparam logic [RX_CNT_W-1:0] FULL = RX_CNT_W'(RX_BYTE_W);

    rx_phase_t            phase;
    logic [RX_BYTE_W-1:0] shreg;
    logic [RX_CNT_W-1:0]  bit_cnt;
    logic                 selected;
    logic                 addr_hit;

    // Address match: fixed high part, strapped low part, direction must be write.
    always_comb begin
        addr_hit = (shreg[RX_BYTE_W-1 -: ADDR_W] == {ADDR_HI, strap_addr})
                   && !shreg[0];
    end

    // Protocol sequencer; bus conditions override any byte in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            shreg     <= '0;
            bit_cnt   <= '0;
            selected  <= 1'b0;
            pull_low  <= 1'b0;
            rx_byte   <= '0;
            rx_valid  <= 1'b0;
            stop_seen <= 1'b0;
        end else begin
            rx_valid  <= 1'b0;
            stop_seen <= 1'b0;
            if (stop_det) begin
                phase     <= PH_IDLE;
                pull_low  <= 1'b0;
                stop_seen <= selected;
                selected  <= 1'b0;
                bit_cnt   <= '0;
            end else if (start_det) begin
                phase    <= PH_ADDR;
                pull_low <= 1'b0;
                bit_cnt  <= '0;
            end else begin
                unique case (phase)
                    PH_ADDR, PH_DATA: begin
                        if (scl_rise && bit_cnt != FULL) begin
                            shreg   <= {shreg[RX_BYTE_W-2:0], sda_now};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == FULL) begin
                            if (phase == PH_DATA) begin
                                pull_low <= 1'b1;
                                phase    <= PH_DATA_ACK;
                            end else if (addr_hit) begin
                                pull_low <= 1'b1;
                                selected <= 1'b1;
                                phase    <= PH_ADDR_ACK;
                            end else begin
                                selected <= 1'b0;
                                phase    <= PH_SKIP;
                            end
                        end
                    end
                    PH_ADDR_ACK, PH_DATA_ACK: begin
                        if (scl_fall) begin
                            pull_low <= 1'b0;
                            bit_cnt  <= '0;
                            phase    <= PH_DATA;
                            if (phase == PH_DATA_ACK) begin
                                rx_byte  <= shreg;
                                rx_valid <= 1'b1;
                            end
                        end
                    end
                    default: ; // PH_IDLE, PH_SKIP: wait for a bus condition
                endcase
            end
        end
    end
endmodule

// File: rtl/twowire_wr_target.sv
// Top of the write-only two-wire bus target receiver. Ties the line sampler
// to the byte engine. Assumes an open-drain pad outside: sda_pull_low = 1
// pulls SDA low, 0 releases it.
module twowire_wr_target #(
    parameter int         SYNC_STAGES = 2,
    parameter int         HI_W        = 5,
    parameter logic [4:0] ADDR_HI     = 5'b10101,
    parameter int         STRAP_W     = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] strap_addr,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_pull_low,
    output logic [7:0]         rx_byte,
    output logic               rx_valid,
    output logic               stop_seen
);
    logic scl_sync, sda_sync, scl_rise, scl_fall, start_det, stop_det;

    twowire_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_raw   (scl_in),
        .sda_raw   (sda_in),
        .scl_now   (scl_sync),
        .sda_now   (sda_sync),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    twowire_rx_engine #(
        .HI_W    (HI_W),
        .ADDR_HI (ADDR_HI[HI_W-1:0]),
        .STRAP_W (STRAP_W)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_addr (strap_addr),
        .sda_now    (sda_sync),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .pull_low   (sda_pull_low),
        .rx_byte    (rx_byte),
        .rx_valid   (rx_valid),
        .stop_seen  (stop_seen)
    );
endmodule

// File: rtl/twowire_wr_target_chk.sv
// Protocol checker for twowire_wr_target, attached with bind below.
// Assumes the top exposes its synchronized SCL and condition strobes.
module twowire_wr_target_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_sync,
    input logic start_det,
    input logic stop_det,
    input logic sda_pull_low,
    input logic rx_valid,
    input logic stop_seen
);
    // R2: the acknowledge drive only moves while SCL is low.
    assert_ack_edge_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_low) |-> !scl_sync);

    // R3: byte strobe lasts one cycle and comes after the line is released.
    assert_valid_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    assert_valid_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !sda_pull_low);

    // R6: a (repeated) START releases SDA.
    assert_start_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_pull_low);

    // R7: a STOP releases SDA; its pulse is one cycle wide.
    assert_stop_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_pull_low);
    assert_stop_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_seen |=> !stop_seen);

    // R9: outputs quiet while reset is held.
    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R9: assert (!sda_pull_low && !rx_valid && !stop_seen);
        end
    end
endmodule

bind twowire_wr_target twowire_wr_target_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_sync     (scl_sync),
    .start_det    (start_det),
    .stop_det     (stop_det),
    .sda_pull_low (sda_pull_low),
    .rx_valid     (rx_valid),
    .stop_seen    (stop_seen)
);

// File: tb/test_twowire_wr_target.sv
// Bench for twowire_wr_target: wired-AND bus model, directed corners plus
// seeded random transactions, expectations from bench functions.
module test_twowire_wr_target;
    localparam int Q = 5;   // setup/hold quarter phase, system cycles
    localparam int H = 10;  // SCL high time, system cycles

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] strap_addr = 2'b00;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_in;
    logic       sda_pull_low;
    logic [7:0] rx_byte;
    logic       rx_valid;
    logic       stop_seen;

    int n_checks = 0;
    int n_fail   = 0;
    int n_valid  = 0;
    int n_stop   = 0;
    int bad_drive = 0;
    logic [7:0] last_byte = '0;
    bit done = 0;

    always #5 clk = ~clk;

    assign sda_in = sda_m & ~sda_pull_low;

    twowire_wr_target i_twowire_wr_target (
        .clk          (clk),
        .rst_n        (rst_n),
        .strap_addr   (strap_addr),
        .scl_in       (scl_m),
        .sda_in       (sda_in),
        .sda_pull_low (sda_pull_low),
        .rx_byte      (rx_byte),
        .rx_valid     (rx_valid),
        .stop_seen    (stop_seen)
    );

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                n_valid++;
                last_byte = rx_byte;
            end
            if (stop_seen) n_stop++;
        end
    end

    function automatic bit exp_ack(input logic [6:0] a7, input bit rw, input logic [1:0] st);
        return (a7 == {5'b10101, st}) && !rw;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // START or repeated START; begins and ends with SCL low (or idle).
    task automatic bus_start();
        sda_m = 1'b1; cyc(Q);
        scl_m = 1'b1; cyc(Q);
        sda_m = 1'b0; cyc(Q);
        scl_m = 1'b0; cyc(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; cyc(Q);
        scl_m = 1'b1; cyc(Q);
        sda_m = 1'b1; cyc(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            sda_m = b[i]; cyc(Q);
            scl_m = 1'b1; cyc(H / 2);
            if (sda_pull_low) bad_drive++;
            cyc(H / 2);
            scl_m = 1'b0; cyc(Q);
        end
    endtask

    // Full byte plus acknowledge clock; ack is 1 if SDA held low all high phase.
    task automatic send_byte(input logic [7:0] b, output bit ack);
        bit a0, a1;
        send_bits(b, 8);
        sda_m = 1'b1; cyc(Q);
        scl_m = 1'b1; cyc(1);
        a0 = ~sda_in;
        cyc(H - 2);
        a1 = ~sda_in;
        cyc(1);
        scl_m = 1'b0; cyc(Q);
        ack = a0 & a1;
    endtask

    // Full transaction with expected-value checks on every byte.
    task automatic do_txn(input logic [6:0] a7, input bit rw, input int nbytes);
        bit ack, hit;
        int v0, s0;
        logic [7:0] d;
        hit = exp_ack(a7, rw, strap_addr);
        bad_drive = 0;
        s0 = n_stop;
        bus_start();
        send_byte({a7, rw}, ack);
        check(ack == hit, "R1 address ack", ack, hit);
        for (int k = 0; k < nbytes; k++) begin
            d = 8'($urandom);
            v0 = n_valid;
            send_byte(d, ack);
            check(ack == hit, hit ? "R3 data ack" : "R4 data not acked", ack, hit);
            check((n_valid - v0) == int'(hit), hit ? "R3 valid pulse" : "R4 no valid", n_valid - v0, int'(hit));
            if (hit) check(last_byte == d, "R3 byte value", last_byte, d);
        end
        check(bad_drive == 0, "R2 released during data bits", bad_drive, 0);
        bus_stop();
        cyc(Q);
        check((n_stop - s0) == int'(hit), "R7 stop pulse", n_stop - s0, int'(hit));
    endtask

    initial begin
        bit ack;
        int v0, s0;
        logic [6:0] a7;
        void'($urandom(32'h1c2a5));
        cyc(4);
        check(sda_pull_low == 0 && rx_valid == 0 && stop_seen == 0, "R9 reset outputs",
              {sda_pull_low, rx_valid, stop_seen}, 0);
        rst_n = 1'b1;
        cyc(4);

        // R1/R3/R7: each strap setting with a matching write.
        for (int s = 0; s < 4; s++) begin
            strap_addr = 2'(s);
            do_txn({5'b10101, 2'(s)}, 1'b0, 3);
        end

        // R4: strap bit mismatch, upper bit mismatch, read direction.
        strap_addr = 2'b10;
        do_txn(7'b1010111, 1'b0, 2);
        do_txn(7'b0010110, 1'b0, 1);
        do_txn(7'b1010110, 1'b1, 2);

        // R5: full matching byte with no START in front of it.
        v0 = n_valid;
        send_byte({7'b1010110, 1'b0}, ack);
        check(ack == 0, "R5 no ack without START", ack, 0);
        send_byte(8'h5a, ack);
        check(n_valid == v0 && ack == 0, "R5 no valid without START", n_valid - v0, 0);

        // R6: repeated START keeps the transaction, no stop pulse at Sr.
        s0 = n_stop; v0 = n_valid;
        bus_start();
        send_byte(8'hac, ack);
        send_byte(8'h3c, ack);
        bus_start();
        check(n_stop == s0, "R6 no stop pulse at repeated START", n_stop - s0, 0);
        send_byte(8'hac, ack);
        check(ack == 1, "R6 address acked after repeated START", ack, 1);
        send_byte(8'hc3, ack);
        check(ack == 1 && last_byte == 8'hc3, "R6 data after repeated START", last_byte, 8'hc3);
        bus_stop(); cyc(Q);
        check(n_valid - v0 == 2 && n_stop - s0 == 1, "R6 two bytes one stop",
              (n_valid - v0) * 10 + (n_stop - s0), 21);

        // R8: STOP mid-byte discards the partial byte.
        s0 = n_stop; v0 = n_valid;
        bus_start();
        send_byte(8'hac, ack);
        send_bits(8'hff, 4);
        bus_stop(); cyc(Q);
        check(n_valid == v0, "R8 no valid after STOP mid-byte", n_valid - v0, 0);
        check(n_stop - s0 == 1, "R8 stop pulse after cut byte", n_stop - s0, 1);

        // R8: repeated START mid-byte, next address still aligned.
        v0 = n_valid;
        bus_start();
        send_byte(8'hac, ack);
        send_bits(8'h00, 5);
        bus_start();
        send_byte(8'hac, ack);
        check(ack == 1, "R8 address realigned after cut byte", ack, 1);
        send_byte(8'h81, ack);
        bus_stop(); cyc(Q);
        check(n_valid - v0 == 1 && last_byte == 8'h81, "R8 only full byte reported",
              n_valid - v0, 1);

        // R7: stop after a rejected address via repeated START gives no pulse.
        s0 = n_stop;
        bus_start();
        send_byte(8'hac, ack);
        bus_start();
        send_byte(8'hae, ack);
        bus_stop(); cyc(Q);
        check(n_stop == s0, "R7 no stop pulse after rejected address", n_stop - s0, 0);

        // Random mix of matching and near-miss transactions.
        for (int t = 0; t < 24; t++) begin
            strap_addr = 2'($urandom);
            a7 = {5'b10101, 2'($urandom)};
            if ($urandom_range(0, 3) == 0) a7 = 7'($urandom);
            do_txn(a7, ($urandom_range(0, 4) == 0), $urandom_range(1, 4));
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule